// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port

This block is a byte-wide synchronous serial port. A single shift engine serves two roles chosen by a 4-bit role field. As bus master it produces the serial clock from the system clock and starts a byte exchange whenever software writes a transmit byte. As bus slave it follows a serial clock and a select line from outside. Every exchange is full duplex and moves the most significant bit first. The byte that arrives is copied into a holding buffer, separate from the shift register, where software reads it.

A polarity input sets the level the serial clock rests at. The leading edge, which leaves the rest level, samples incoming data. The trailing edge, which returns to the rest level, shifts the register and presents the next outgoing bit. Software gets two flags: one shows that the buffer holds an unread byte, and the other shows that a transmit write was refused. Dropping the enable input puts every register of the port back into its reset state. The port is then reconfigured and enabled again.

Top module: `spi_port`

## Requirements
- R1: After `rst`, and on the cycle after any cycle with `en_i` low, the port is in its reset state: `buf_full_o`=0, `wcol_o`=0, `rx_data_o`=0 and `sck_o` equals `cpol_i`. While `en_i` is low, `sdo_en_o` is 0.
- R2: A `mode_i` value of the form 00xx selects master and 010x selects slave. Any other value holds the port in reset: writes are ignored, `sck_o` stays at `cpol_i`, `buf_full_o` stays 0 and `sdo_en_o` is 0.
- R3: In master mode, each half-period of `sck_o` lasts H system clocks, with H = 2, 8, 32, 2 for `mode_i[1:0]` = 00, 01, 10, 11 (a clock divide of 4, 16, 64, 4). One byte makes exactly 16 transitions of `sck_o`.
- R4: `sck_o` rests at `cpol_i`. Incoming data is sampled on the transition away from `cpol_i`. The register shifts on the transition back to `cpol_i`.
- R5: A master exchange drives the written byte on `sdo_o` MSB first, valid at each leading edge. It returns the 8 bits sampled from `sdi_i`, MSB first, in `rx_data_o`.
- R6: A master write accepted at clock edge E sets `buf_full_o` and loads `rx_data_o` at edge E+16·H, and not before. `buf_full_o` then stays set until a cycle with `rx_rd_i` high, after which it reads 0.
- R7: A write while a byte is in progress is ignored. The byte in flight is unchanged, and `wcol_o` is set on the next cycle and stays set until the port is disabled.
- R8: In slave mode, the port shifts on edges of `sck_i`. It exchanges its loaded transmit byte for the incoming byte, sets `buf_full_o` and loads `rx_data_o` after the eighth trailing edge.
- R9: In slave mode, `ss_n_i` high clears the bit counter and drives `sdo_en_o` to 0. A partial byte cut off by `ss_n_i` is discarded, and the next byte is counted from its first bit.
- R10: Disabling the port in the middle of a master byte stops `sck_o` at the rest level and sets no flag. After the port is enabled again, the next write completes a normal exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Port enable; low resets the port |
| mode_i | input | 4 | Role and master rate field |
| cpol_i | input | 1 | Serial clock rest level |
| tx_wr_i | input | 1 | Transmit write strobe |
| tx_data_i | input | 8 | Transmit byte |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| rx_data_o | output | 8 | Receive buffer contents |
| buf_full_o | output | 1 | Receive buffer holds an unread byte |
| wcol_o | output | 1 | Refused-write flag |
| sck_i | input | 1 | Serial clock from outside (slave) |
| sck_o | output | 1 | Serial clock generated (master) |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | High when `sdo_o` is driven, low for high impedance |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
In master mode the receive buffer is due exactly 16·H clocks after the accepted write. The bench checks that `buf_full_o` is still low one cycle before that edge and high right after it, and a serial peer in the bench checks every half-period as H clocks. The collision flag, the buffer clear after a read and the reset state after disable are each due one clock after their stimulus, so they are sampled on the falling edge that follows. Slave events pass through a synchronizer and land within three clocks of a trailing edge. The bench therefore moves its serial clock only every eight clocks and reads the results six clocks after the last edge.

// File: rtl/spi_pkg.sv
package spi_pkg;

    typedef enum logic [1:0] {
        ROLE_OFF    = 2'd0,
        ROLE_MASTER = 2'd1,
        ROLE_SLAVE  = 2'd2
    } role_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } sck_ev_t;

    localparam int unsigned MAX_HALF = 32;
    localparam int unsigned HALF_W   = $clog2(MAX_HALF);

    function automatic role_e decode_role(input logic [3:0] m);
        casez (m)
            4'b00??: return ROLE_MASTER;
            4'b010?: return ROLE_SLAVE;
            default: return ROLE_OFF;
        endcase
    endfunction

    function automatic int unsigned half_period(input logic [1:0] sel);
        case (sel)
            2'b01:   return 8;
            2'b10:   return MAX_HALF;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen
    import spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] sel,
    output sck_ev_t    ev,
    output logic       phase
);

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] limit;
    logic              tick;

    assign limit = HALF_W'(half_period(sel) - 1);
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ev.lead  = tick && !phase;
    assign ev.trail = tick && phase;

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3

endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front
    import spi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cpol,
    input  logic    sck_i,
    input  logic    sdi_i,
    input  logic    ss_n_i,
    output sck_ev_t ev,
    output logic    sdi_s,
    output logic    ss_n_s
);

    logic [STAGES:0]   sck_p;
    logic [STAGES-1:0] sdi_p;
    logic [STAGES-1:0] ss_p;
    logic              sck_now;
    logic              sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= {(STAGES+1){cpol}};
            sdi_p <= '0;
            ss_p  <= '1;
        end else begin
            sck_p <= {sck_p[STAGES-1:0], sck_i};
            sdi_p <= {sdi_p[STAGES-2:0], sdi_i};
            ss_p  <= {ss_p[STAGES-2:0], ss_n_i};
        end
    end

    assign sck_now  = sck_p[STAGES-1];
    assign sck_prev = sck_p[STAGES];
    assign sdi_s    = sdi_p[STAGES-1];
    assign ss_n_s   = ss_p[STAGES-1];

    assign ev.lead  = (sck_now != sck_prev) && (sck_now != cpol);
    assign ev.trail = (sck_now != sck_prev) && (sck_now == cpol);

endmodule

// File: rtl/spi_shift.sv
module spi_shift
    import spi_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  sck_ev_t      ev,
    input  logic         sdi_bit,
    input  logic         hold,
    output logic         sdo,
    output logic         in_prog,
    output logic         done,
    output logic [W-1:0] rx_word
);

    localparam int CW = $clog2(W);

    logic [W-1:0]  sr;
    logic          smp;
    logic          mid;
    logic [CW-1:0] cnt;

    assign done    = ev.trail && mid && !hold && (cnt == CW'(W - 1));
    assign rx_word = {sr[W-2:0], smp};
    assign sdo     = sr[W-1];
    assign in_prog = mid || (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            smp <= 1'b0;
            mid <= 1'b0;
            cnt <= '0;
        end else begin
            if (load) begin
                sr <= load_data;
            end
            if (hold) begin
                cnt <= '0;
                mid <= 1'b0;
            end else begin
                if (ev.lead) begin
                    smp <= sdi_bit;
                    mid <= 1'b1;
                end
                if (ev.trail && mid) begin
                    sr  <= {sr[W-2:0], smp};
                    mid <= 1'b0;
                    cnt <= done ? '0 : cnt + 1'b1;
                end
            end
        end
    end

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hold |=> !in_prog); // R9

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [3:0]        mode_i,
    input  logic              cpol_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              rx_rd_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              buf_full_o,
    output logic              wcol_o,
    input  logic              sck_i,
    output logic              sck_o,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    input  logic              ss_n_i
);

    role_e             role;
    logic              active;
    logic              port_rst;
    logic              is_m;
    logic              is_s;
    sck_ev_t           gen_ev;
    sck_ev_t           fr_ev;
    sck_ev_t           ev;
    logic              phase;
    logic              m_busy;
    logic              sh_inprog;
    logic              in_prog;
    logic              accept;
    logic              sh_done;
    logic              sh_sdo;
    logic              sdi_s;
    logic              ss_n_s;
    logic              hold;
    logic              sdi_bit;
    logic [DATA_W-1:0] sh_rx_word;
    logic [DATA_W-1:0] rxbuf;
    logic              full_q;
    logic              wcol_q;

    assign role     = decode_role(mode_i);
    assign is_m     = (role == ROLE_MASTER);
    assign is_s     = (role == ROLE_SLAVE);
    assign active   = en_i && (role != ROLE_OFF);
    assign port_rst = rst || !active;

    assign in_prog = m_busy || sh_inprog;
    assign accept  = tx_wr_i && !in_prog;
    assign ev      = is_m ? gen_ev : fr_ev;
    assign sdi_bit = is_m ? sdi_i : sdi_s;
    assign hold    = is_s && ss_n_s;

    spi_clkgen u_clkgen (
        .clk   (clk),
        .rst   (port_rst),
        .run   (m_busy),
        .sel   (mode_i[1:0]),
        .ev    (gen_ev),
        .phase (phase)
    );

    spi_slave_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk    (clk),
        .rst    (port_rst),
        .cpol   (cpol_i),
        .sck_i  (sck_i),
        .sdi_i  (sdi_i),
        .ss_n_i (ss_n_i),
        .ev     (fr_ev),
        .sdi_s  (sdi_s),
        .ss_n_s (ss_n_s)
    );

    spi_shift #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (port_rst),
        .load      (accept),
        .load_data (tx_data_i),
        .ev        (ev),
        .sdi_bit   (sdi_bit),
        .hold      (hold),
        .sdo       (sh_sdo),
        .in_prog   (sh_inprog),
        .done      (sh_done),
        .rx_word   (sh_rx_word)
    );

    always_ff @(posedge clk) begin
        if (port_rst) begin
            m_busy <= 1'b0;
        end else if (accept && is_m) begin
            m_busy <= 1'b1;
        end else if (sh_done) begin
            m_busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (port_rst) begin
            rxbuf  <= '0;
            full_q <= 1'b0;
        end else if (sh_done) begin
            rxbuf  <= sh_rx_word;
            full_q <= 1'b1;
        end else if (rx_rd_i) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (port_rst) begin
            wcol_q <= 1'b0;
        end else if (tx_wr_i && in_prog) begin
            wcol_q <= 1'b1;
        end
    end

    assign rx_data_o  = rxbuf;
    assign buf_full_o = full_q;
    assign wcol_o     = wcol_q;
    assign sck_o      = cpol_i ^ (is_m && phase);
    assign sdo_o      = sh_sdo;
    assign sdo_en_o   = active && (is_m || (is_s && !ss_n_s));

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!buf_full_o && !wcol_o && (sck_o == cpol_i))); // R1

    AST_WCOL_SET: assert property (@(posedge clk) disable iff (rst)
        (tx_wr_i && in_prog && !port_rst) |=> wcol_o); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rx_rd_i && !sh_done && !port_rst) |=> !buf_full_o); // R6

    AST_FULL_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (sh_done && !port_rst) |=> (buf_full_o && (rx_data_o == $past(sh_rx_word)))); // R6

endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0;
    logic [3:0] mode_i = 4'b0000;
    logic       cpol_i = 1'b0;
    logic       tx_wr_i = 1'b0;
    logic [7:0] tx_data_i = 8'h00;
    logic       rx_rd_i = 1'b0;
    logic [7:0] rx_data_o;
    logic       buf_full_o;
    logic       wcol_o;
    logic       sck_i = 1'b0;
    logic       sck_o;
    logic       sdi_i;
    logic       sdo_o;
    logic       sdo_en_o;
    logic       ss_n_i = 1'b1;

    always #2.5 clk = ~clk;

    spi_port dut (
        .clk(clk), .rst(rst), .en_i(en_i), .mode_i(mode_i), .cpol_i(cpol_i),
        .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i), .rx_rd_i(rx_rd_i),
        .rx_data_o(rx_data_o), .buf_full_o(buf_full_o), .wcol_o(wcol_o),
        .sck_i(sck_i), .sck_o(sck_o), .sdi_i(sdi_i), .sdo_o(sdo_o),
        .sdo_en_o(sdo_en_o), .ss_n_i(ss_n_i)
    );

    int n_chk = 0;
    int n_fail = 0;
    int idle_chk = 0;
    int idle_fail = 0;
    int cyc = 0;
    bit exp_idle = 1'b0;

    // serial peer acting as slave for master-mode transfers
    bit         use_peer = 1'b1;
    logic       peer_sdi = 1'b0;
    logic       slv_sdi = 1'b0;
    logic [7:0] peer_tx = 8'h00;
    logic [7:0] peer_rx = 8'h00;
    int         peer_half = 2;
    int         peer_req = 0;
    int         peer_seen = 0;
    int         peer_idx = 0;
    int         n_edge = 0;
    int         bad_iv = 0;
    int         last_chg = 0;
    bit         first = 1'b1;
    logic       prev_sck = 1'b0;

    assign sdi_i = use_peer ? peer_sdi : slv_sdi;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (peer_req != peer_seen) begin
            peer_seen = peer_req;
            peer_rx   = 8'h00;
            peer_idx  = 0;
            n_edge    = 0;
            bad_iv    = 0;
            first     = 1'b1;
            peer_sdi  = peer_tx[7];
            prev_sck  = sck_o;
        end else begin
            if (sck_o != prev_sck) begin
                n_edge++;
                if (!first && (cyc - last_chg != peer_half)) bad_iv++;
                first    = 1'b0;
                last_chg = cyc;
                if (sck_o != cpol_i) begin
                    peer_rx = {peer_rx[6:0], sdo_o};
                end else begin
                    peer_idx++;
                    if (peer_idx < 8) peer_sdi = peer_tx[7 - peer_idx];
                end
            end
            prev_sck = sck_o;
        end
    end

    // every-clock comparison: the serial clock rests at the polarity level when idle (R4)
    always @(negedge clk) begin
        if (!rst && exp_idle) begin
            idle_chk++;
            if (sck_o != cpol_i) begin
                idle_fail++;
                $display("FAIL R4 idle sck act=%0d exp=%0d at cycle %0d", sck_o, cpol_i, cyc);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic m_xfer(input logic [7:0] tx, input logic [7:0] pv, input int half, input int wc);
        @(negedge clk);
        peer_tx   = pv;
        peer_half = half;
        use_peer  = 1'b1;
        peer_req++;
        tx_data_i = tx;
        tx_wr_i   = 1'b1;
        rx_rd_i   = 1'b1;
        exp_idle  = 1'b0;
        @(negedge clk);
        tx_wr_i = 1'b0;
        rx_rd_i = 1'b0;
        for (int k = 1; k <= 16 * half - 1; k++) begin
            @(negedge clk);
            if (wc > 0 && k == wc) begin
                tx_wr_i   = 1'b1;
                tx_data_i = ~tx;
            end else if (wc > 0 && k == wc + 1) begin
                tx_wr_i = 1'b0;
                check(wcol_o == 1'b1, "R7 collision flag after busy write", int'(wcol_o), 1);
            end
        end
        check(buf_full_o == 1'b0, "R6 buffer full one cycle early", int'(buf_full_o), 0);
        check(sdo_en_o == 1'b1, "R2 master drives data out", int'(sdo_en_o), 1);
        @(negedge clk);
        check(buf_full_o == 1'b1, "R6 buffer full at 16*H", int'(buf_full_o), 1);
        check(rx_data_o == pv, "R5 received byte", int'(rx_data_o), int'(pv));
        @(negedge clk);
        check(peer_rx == tx, "R5 transmitted byte MSB first", int'(peer_rx), int'(tx));
        check(n_edge == 16, "R3 sck transitions per byte", n_edge, 16);
        check(bad_iv == 0, "R3 half-period length", bad_iv, 0);
        exp_idle = 1'b1;
    endtask

    task automatic s_setup(input logic c, input logic [3:0] m);
        @(negedge clk);
        exp_idle = 1'b0;
        en_i     = 1'b0;
        cpol_i   = c;
        mode_i   = m;
        sck_i    = c;
        ss_n_i   = 1'b1;
        use_peer = 1'b0;
        @(negedge clk);
        en_i = 1'b1;
        exp_idle = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic s_xfer(input logic [7:0] mo, input int nbits, output logic [7:0] cap);
        cap = 8'h00;
        slv_sdi = mo[7];
        for (int b = 0; b < nbits; b++) begin
            repeat (8) @(negedge clk);
            sck_i = ~cpol_i;
            cap = {cap[6:0], sdo_o};
            repeat (8) @(negedge clk);
            sck_i = cpol_i;
            if (b < 7) slv_sdi = mo[6 - b];
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic write_tx(input logic [7:0] d, input bit rd);
        @(negedge clk);
        tx_data_i = d;
        tx_wr_i   = 1'b1;
        rx_rd_i   = rd;
        @(negedge clk);
        tx_wr_i = 1'b0;
        rx_rd_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
        $display("%0d/%0d checks passed", (n_chk + idle_chk) - (n_fail + idle_fail + 1),
                 n_chk + idle_chk + 1);
        $finish;
    end

    initial begin : main
        logic [7:0] cap;
        repeat (4) @(negedge clk);
        check(buf_full_o == 1'b0, "R1 reset buffer flag", int'(buf_full_o), 0);
        check(wcol_o == 1'b0, "R1 reset collision flag", int'(wcol_o), 0);
        check(rx_data_o == 8'h00, "R1 reset buffer data", int'(rx_data_o), 0);
        check(sck_o == cpol_i, "R1 reset sck level", int'(sck_o), int'(cpol_i));
        check(sdo_en_o == 1'b0, "R1 disabled data out released", int'(sdo_en_o), 0);
        rst = 1'b0;
        @(negedge clk);
        en_i = 1'b1;
        exp_idle = 1'b1;
        repeat (2) @(negedge clk);

        // master, divide by 4, polarity 0
        m_xfer(8'hA5, 8'h3C, 2, 0);
        @(negedge clk);
        rx_rd_i = 1'b1;
        @(negedge clk);
        rx_rd_i = 1'b0;
        check(buf_full_o == 1'b0, "R6 read clears buffer flag", int'(buf_full_o), 0);

        // master, divide by 16, polarity 1
        @(negedge clk);
        cpol_i = 1'b1;
        mode_i = 4'b0001;
        @(negedge clk);
        check(sck_o == 1'b1, "R4 rest level follows polarity", int'(sck_o), 1);
        m_xfer(8'h81, 8'h7E, 8, 0);

        // master, divide by 64
        @(negedge clk);
        mode_i = 4'b0010;
        m_xfer(8'h5A, 8'hC3, 32, 0);

        // master, low bits 11 act as divide by 4
        @(negedge clk);
        mode_i = 4'b0011;
        cpol_i = 1'b0;
        m_xfer(8'h0F, 8'hF0, 2, 0);

        // write collision during a transfer
        m_xfer(8'h6D, 8'h92, 2, 7);
        check(wcol_o == 1'b1, "R7 collision flag sticky", int'(wcol_o), 1);

        // disable in the middle of a transfer
        @(negedge clk);
        exp_idle  = 1'b0;
        tx_data_i = 8'h33;
        tx_wr_i   = 1'b1;
        @(negedge clk);
        tx_wr_i = 1'b0;
        repeat (10) @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        check(buf_full_o == 1'b0, "R10 disable clears buffer flag", int'(buf_full_o), 0);
        check(wcol_o == 1'b0, "R1 disable clears collision flag", int'(wcol_o), 0);
        check(sck_o == cpol_i, "R10 disable parks sck", int'(sck_o), int'(cpol_i));
        check(sdo_en_o == 1'b0, "R1 disabled data out released", int'(sdo_en_o), 0);
        check(rx_data_o == 8'h00, "R1 disable clears buffer data", int'(rx_data_o), 0);
        en_i = 1'b1;
        exp_idle = 1'b1;
        @(negedge clk);
        check(buf_full_o == 1'b0, "R10 no flag after re-enable", int'(buf_full_o), 0);
        m_xfer(8'hC6, 8'h19, 2, 0);

        // unsupported role code holds the port in reset
        @(negedge clk);
        mode_i   = 4'b1000;
        peer_req++;
        write_tx(8'hFF, 1'b1);
        repeat (40) @(negedge clk);
        check(n_edge == 0, "R2 no sck activity in unsupported mode", n_edge, 0);
        check(buf_full_o == 1'b0, "R2 no buffer flag in unsupported mode", int'(buf_full_o), 0);
        check(sdo_en_o == 1'b0, "R2 data out released in unsupported mode", int'(sdo_en_o), 0);

        // slave, polarity 0
        s_setup(1'b0, 4'b0100);
        check(sdo_en_o == 1'b0, "R9 deselected slave releases data out", int'(sdo_en_o), 0);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        check(sdo_en_o == 1'b1, "R9 selected slave drives data out", int'(sdo_en_o), 1);
        write_tx(8'h96, 1'b0);
        s_xfer(8'h4B, 8, cap);
        check(buf_full_o == 1'b1, "R8 slave buffer flag", int'(buf_full_o), 1);
        check(rx_data_o == 8'h4B, "R8 slave received byte", int'(rx_data_o), 8'h4B);
        check(cap == 8'h96, "R8 slave transmitted byte", int'(cap), 8'h96);

        // slave select cut-off discards a partial byte
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check(sdo_en_o == 1'b0, "R9 deselect releases data out", int'(sdo_en_o), 0);
        write_tx(8'h2D, 1'b1);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        s_xfer(8'hA0, 3, cap);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check(buf_full_o == 1'b0, "R9 partial byte sets no flag", int'(buf_full_o), 0);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        s_xfer(8'hE1, 8, cap);
        check(buf_full_o == 1'b1, "R9 full byte after cut-off", int'(buf_full_o), 1);
        check(rx_data_o == 8'hE1, "R9 bit count restarted", int'(rx_data_o), 8'hE1);

        // slave, polarity 1
        s_setup(1'b1, 4'b0101);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        write_tx(8'h6C, 1'b0);
        s_xfer(8'hB2, 8, cap);
        check(rx_data_o == 8'hB2, "R8 slave received byte, polarity 1", int'(rx_data_o), 8'hB2);
        check(cap == 8'h6C, "R4 slave edges with polarity 1", int'(cap), 8'h6C);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", (n_chk + idle_chk) - (n_fail + idle_fail),
                 n_chk + idle_chk);
        $finish;
    end

endmodule